// File: doc/BRIEF.md
# Line-Synchronized Test Pattern Generator

This block produces synthetic pixel words for a serializer input in place of converted sensor samples. Register inputs select a pattern, the length of a leading zero-code start period, the width of the active pixel window, and a constant value used by the fixed-code mode. A line-start strobe frames the output into lines.

Generation is armed when both the global test enable and the pattern enable are high. It starts only at the next rising edge of the line-start strobe. At that arming edge the mode, start length, window width and fixed code are copied into shadow registers, so later register writes have no effect until the block is disarmed and armed again. Every later line-start edge begins a fresh line with the same shadowed settings, and this repeats until an enable is cleared.

Output is registered. A line-start rising edge sampled at clock edge n gives the first pixel of the line on the outputs after clock edge n+1.

Top module: `lineTestPattern`

## Requirements
- R1: While reset is asserted and after it is released, `pixOut` is 0x0000 and `pixValid` is low until a pattern is armed and a line-start edge arrives.
- R2: If `testEn` or `patEn` is low, the outputs go idle (`pixOut` = 0x0000, `pixValid` low) two clock edges later, and line-start edges are ignored. A high `patEn` with `testEn` low produces no output.
- R3: Setting the enables does not start output by itself. The first pixel appears only after a rising edge of `lineStart`. If that edge is sampled at clock edge n, pixel 0 is on the outputs after edge n+1, and pixel p is on the outputs after edge n+1+p.
- R4: Each line begins with `startLen` pixels of 0x0000 with `pixValid` high. A `startLen` of 0 skips the start period.
- R5: After the start period, `validWidth` pattern pixels follow with `pixValid` high and the pixel index x counting 0 to `validWidth`-1. After that the output is 0x0000 with `pixValid` low until the next line-start edge. Whenever `pixValid` is low, `pixOut` is 0x0000.
- R6: `modeSel` 3'b000 outputs the `fixedCode` value. The reserved code 3'b111 outputs 0x0000 in the window with `pixValid` still high.
- R7: Code 3'b001 outputs x. Code 3'b010 outputs the line index, which is 0 on the arming line and increments by one at each later line-start edge.
- R8: Code 3'b011 outputs 0xFFFF when bit 3 of x or bit 3 of the line index is set, and 0x0000 otherwise. Code 3'b100 outputs 0xFFFF when bit 3 of x is set, and 0x0000 otherwise.
- R9: Code 3'b101 outputs 0xAAAA for even x and 0x5555 for odd x, so every line restarts with 0xAAAA. Code 3'b110 alternates 0xAAAA and 0x5555 across all window pixels since arming, starting at 0xAAAA and never restarting at a line start.
- R10: Changes to `modeSel`, `startLen`, `validWidth` or `fixedCode` while armed have no effect. New values are taken only at the arming edge that follows a clear and re-set of `patEn`.
- R11: Every line-start edge while armed starts a new line, including an edge that arrives in the middle of a line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineStart | input | 1 | Line-start strobe; its rising edge starts a line |
| testEn | input | 1 | Global test enable |
| patEn | input | 1 | Pattern enable; set after the parameters are loaded |
| modeSel | input | 3 | Pattern select code |
| startLen | input | CNT_W (12) | Start period length in pixels |
| validWidth | input | CNT_W (12) | Window width in pixels |
| fixedCode | input | PIX_W (16) | Value for the fixed-code mode |
| pixOut | output | PIX_W (16) | Pixel word |
| pixValid | output | 1 | High during the start period and the window |

## Verification
A table runs every mode code once, including the reserved one, over two consecutive lines. Each run compares every pixel of the start period, the window and two tail pixels. Odd window widths make the synchronous and free-running alternations differ on the second line. The vertical gradient run tells the two lines apart. Zero start and zero width cases check the edges of the framing. Directed tests cover these cases:
- an armed-but-waiting state, to show that arming alone starts nothing;
- `patEn` held high with `testEn` low;
- register changes while running, which the output must not follow until a re-arm;
- a line-start edge in the middle of a line;
- a disarm in the middle of a line, checked against the two-edge latency.

// File: rtl/tpgPkg.sv
package tpgPkg;

  typedef enum logic [2:0] {
    MODE_FIXED   = 3'b000,
    MODE_HGRAD   = 3'b001,
    MODE_VGRAD   = 3'b010,
    MODE_LATTICE = 3'b011,
    MODE_STRIPE  = 3'b100,
    MODE_SYNCALT = 3'b101,
    MODE_FREEALT = 3'b110,
    MODE_RSVD    = 3'b111
  } tpgMode_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_START,
    PH_ACTIVE,
    PH_TAIL
  } tpgPhase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic armPulse;
    logic startPer;
    logic pixel;
  } tpgStrobe_t;

endpackage

// File: rtl/tpgControl.sv
module tpgControl
  import tpgPkg::*;
#(
  parameter int CNT_W = 12,
  parameter int PIX_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lineStart,
  input  logic             testEn,
  input  logic             patEn,
  input  logic [2:0]       modeSel,
  input  logic [CNT_W-1:0] startLen,
  input  logic [CNT_W-1:0] validWidth,
  input  logic [PIX_W-1:0] fixedCode,
  output tpgStrobe_t       strobe,
  output logic [CNT_W-1:0] pixIdx,
  output logic [PIX_W-1:0] lineIdx,
  output tpgMode_e         modeSh,
  output logic [PIX_W-1:0] fixedSh
);

  localparam int CW1 = CNT_W + 1;

  logic             lsPrev;
  logic             running;
  tpgPhase_e        phase;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] startSh;
  logic [CNT_W-1:0] widthSh;

  logic             armed;
  logic             lsEdge;
  logic             arming;
  logic [CNT_W-1:0] selStart;
  logic [CNT_W-1:0] selWidth;
  logic             lastStart;
  logic             lastPix;

  always_comb begin
    armed     = testEn & patEn;
    lsEdge    = lineStart & ~lsPrev;
    arming    = armed & lsEdge & ~running;
    selStart  = arming ? startLen : startSh;
    selWidth  = arming ? validWidth : widthSh;
    lastStart = ({1'b0, cnt} + CW1'(1)) == {1'b0, startSh};
    lastPix   = ({1'b0, cnt} + CW1'(1)) == {1'b0, widthSh};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lsPrev  <= 1'b0;
      running <= 1'b0;
      phase   <= PH_IDLE;
      cnt     <= '0;
      lineIdx <= '0;
      startSh <= '0;
      widthSh <= '0;
      modeSh  <= MODE_FIXED;
      fixedSh <= '0;
    end else begin
      lsPrev <= lineStart;
      if (arming) begin
        startSh <= startLen;
        widthSh <= validWidth;
        modeSh  <= tpgMode_e'(modeSel);
        fixedSh <= fixedCode;
      end
      if (!armed) begin
        running <= 1'b0;
        phase   <= PH_IDLE;
        cnt     <= '0;
      end else if (lsEdge) begin
        running <= 1'b1;
        lineIdx <= running ? lineIdx + PIX_W'(1) : '0;
        cnt     <= '0;
        if (selStart != '0)      phase <= PH_START;
        else if (selWidth != '0) phase <= PH_ACTIVE;
        else                     phase <= PH_TAIL;
      end else begin
        unique case (phase)
          PH_START: begin
            if (lastStart) begin
              cnt   <= '0;
              phase <= (widthSh != '0) ? PH_ACTIVE : PH_TAIL;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          PH_ACTIVE: begin
            if (lastPix) begin
              cnt   <= '0;
              phase <= PH_TAIL;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    strobe.armPulse = arming;
    strobe.startPer = (phase == PH_START);
    strobe.pixel    = (phase == PH_ACTIVE);
    pixIdx          = cnt;
  end

endmodule

// File: rtl/tpgDatapath.sv
module tpgDatapath
  import tpgPkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int PIX_W    = 16,
  parameter int TILE_BIT = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  tpgStrobe_t       strobe,
  input  logic [CNT_W-1:0] pixIdx,
  input  logic [PIX_W-1:0] lineIdx,
  input  tpgMode_e         modeSh,
  input  logic [PIX_W-1:0] fixedSh,
  output logic [PIX_W-1:0] pixOut,
  output logic             pixValid
);

  localparam logic [PIX_W-1:0] EVEN_WORD = {(PIX_W/2){2'b10}};
  localparam logic [PIX_W-1:0] ODD_WORD  = {(PIX_W/2){2'b01}};

  logic             altPhase;
  logic [PIX_W-1:0] pattern;

  always_comb begin
    unique case (modeSh)
      MODE_FIXED:   pattern = fixedSh;
      MODE_HGRAD:   pattern = PIX_W'(pixIdx);
      MODE_VGRAD:   pattern = lineIdx;
      MODE_LATTICE: pattern = (pixIdx[TILE_BIT] | lineIdx[TILE_BIT]) ? '1 : '0;
      MODE_STRIPE:  pattern = pixIdx[TILE_BIT] ? '1 : '0;
      MODE_SYNCALT: pattern = pixIdx[0] ? ODD_WORD : EVEN_WORD;
      MODE_FREEALT: pattern = altPhase ? ODD_WORD : EVEN_WORD;
      default:      pattern = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      altPhase <= 1'b0;
      pixOut   <= '0;
      pixValid <= 1'b0;
    end else begin
      if (strobe.armPulse)   altPhase <= 1'b0;
      else if (strobe.pixel) altPhase <= ~altPhase;
      pixOut   <= strobe.pixel ? pattern : '0;
      pixValid <= strobe.pixel | strobe.startPer;
    end
  end

endmodule

// File: rtl/lineTestPattern.sv
module lineTestPattern
  import tpgPkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int PIX_W    = 16,
  parameter int TILE_BIT = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lineStart,
  input  logic             testEn,
  input  logic             patEn,
  input  logic [2:0]       modeSel,
  input  logic [CNT_W-1:0] startLen,
  input  logic [CNT_W-1:0] validWidth,
  input  logic [PIX_W-1:0] fixedCode,
  output logic [PIX_W-1:0] pixOut,
  output logic             pixValid
);

  tpgStrobe_t       strobe;
  logic [CNT_W-1:0] pixIdx;
  logic [PIX_W-1:0] lineIdx;
  tpgMode_e         modeSh;
  logic [PIX_W-1:0] fixedSh;

  tpgControl #(.CNT_W(CNT_W), .PIX_W(PIX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .lineStart(lineStart), .testEn(testEn),
    .patEn(patEn), .modeSel(modeSel), .startLen(startLen),
    .validWidth(validWidth), .fixedCode(fixedCode), .strobe(strobe),
    .pixIdx(pixIdx), .lineIdx(lineIdx), .modeSh(modeSh), .fixedSh(fixedSh)
  );

  tpgDatapath #(.CNT_W(CNT_W), .PIX_W(PIX_W), .TILE_BIT(TILE_BIT)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pixIdx(pixIdx),
    .lineIdx(lineIdx), .modeSh(modeSh), .fixedSh(fixedSh),
    .pixOut(pixOut), .pixValid(pixValid)
  );

endmodule

// File: rtl/tpgChecker.sv
module tpgChecker
  import tpgPkg::*;
#(
  parameter int CNT_W = 12,
  parameter int PIX_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             lineStart,
  input logic             testEn,
  input logic             patEn,
  input logic [PIX_W-1:0] pixOut,
  input logic             pixValid,
  input tpgStrobe_t       strobe,
  input logic [CNT_W-1:0] pixIdx
);

  // R2
  idle_when_disarmed_chk: assert property (@(posedge clk) disable iff (!rstN)
    !($past(testEn, 2) && $past(patEn, 2)) |-> (!pixValid && pixOut == '0));

  // R5
  zero_when_invalid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pixValid |-> pixOut == '0);

  // R3
  valid_after_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pixValid) |-> ($past(lineStart, 2) && !$past(lineStart, 3)));

  // R5
  index_steps_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pixel && $past(strobe.pixel) && !($past(lineStart) && !$past(lineStart, 2)))
      |-> pixIdx == $past(pixIdx) + CNT_W'(1));

endmodule

bind lineTestPattern tpgChecker #(.CNT_W(CNT_W), .PIX_W(PIX_W)) u_chk (
  .clk(clk), .rstN(rstN), .lineStart(lineStart), .testEn(testEn),
  .patEn(patEn), .pixOut(pixOut), .pixValid(pixValid),
  .strobe(strobe), .pixIdx(pixIdx)
);

// File: tb/test_lineTestPattern.sv
module test_lineTestPattern;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lineStart = 1'b0;
  logic        testEn = 1'b0;
  logic        patEn = 1'b0;
  logic [2:0]  modeSel = 3'd0;
  logic [11:0] startLen = '0;
  logic [11:0] validWidth = '0;
  logic [15:0] fixedCode = '0;
  logic [15:0] pixOut;
  logic        pixValid;

  int errors = 0;
  int checks = 0;
  int freeCnt = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lineTestPattern i_lineTestPattern (
    .clk(clk), .rstN(rstN), .lineStart(lineStart), .testEn(testEn),
    .patEn(patEn), .modeSel(modeSel), .startLen(startLen),
    .validWidth(validWidth), .fixedCode(fixedCode),
    .pixOut(pixOut), .pixValid(pixValid)
  );

  typedef struct packed {
    logic [2:0]  mode;
    logic [7:0]  s;
    logic [7:0]  w;
    logic [15:0] fx;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{3'd0, 8'd3, 8'd4,  16'h1234},
    '{3'd1, 8'd2, 8'd6,  16'h0000},
    '{3'd2, 8'd0, 8'd3,  16'h0000},
    '{3'd3, 8'd1, 8'd20, 16'h0000},
    '{3'd4, 8'd2, 8'd18, 16'h0000},
    '{3'd5, 8'd1, 8'd5,  16'h0000},
    '{3'd6, 8'd2, 8'd5,  16'h0000},
    '{3'd7, 8'd1, 8'd3,  16'hFFFF},
    '{3'd0, 8'd0, 8'd0,  16'hBEEF}
  };

  task automatic check(input string req, input logic [16:0] act, input logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got valid=%0b pix=%h, expected valid=%0b pix=%h",
               req, act[16], act[15:0], exp[16], exp[15:0]);
    end
  endtask

  function automatic logic [15:0] expPattern(input int mode, input int x, input int line, input int fc,
                                             input logic [15:0] fx);
    case (mode)
      0: return fx;
      1: return 16'(x);
      2: return 16'(line);
      3: return (x[3] || line[3]) ? 16'hFFFF : 16'h0000;
      4: return x[3] ? 16'hFFFF : 16'h0000;
      5: return x[0] ? 16'h5555 : 16'hAAAA;
      6: return fc[0] ? 16'h5555 : 16'hAAAA;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic string modeReq(input int mode);
    case (mode)
      0, 7: return "R6";
      1, 2: return "R7";
      3, 4: return "R8";
      default: return "R9";
    endcase
  endfunction

  // pulse line start, then compare nChk pixels
  task automatic runLine(input int mode, input int s, input int w, input logic [15:0] fx,
                         input int line, input int nChk);
    lineStart = 1'b1;
    @(negedge clk);
    lineStart = 1'b0;
    for (int p = 0; p < nChk; p++) begin
      @(negedge clk);
      if (p < s) begin
        check("R4", {pixValid, pixOut}, {1'b1, 16'h0000});
      end else if (p < s + w) begin
        check(modeReq(mode), {pixValid, pixOut},
              {1'b1, expPattern(mode, p - s, line, freeCnt, fx)});
        freeCnt++;
      end else begin
        check("R5", {pixValid, pixOut}, {1'b0, 16'h0000});
      end
    end
  endtask

  task automatic armWith(input int mode, input int s, input int w, input logic [15:0] fx);
    patEn = 1'b0;
    repeat (3) @(negedge clk);
    modeSel = 3'(mode);
    startLen = 12'(s);
    validWidth = 12'(w);
    fixedCode = fx;
    testEn = 1'b1;
    patEn = 1'b1;
    freeCnt = 0;
    repeat (3) begin
      @(negedge clk);
      check("R3", {pixValid, pixOut}, 17'h0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got running, expected finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    @(negedge clk);
    check("R1", {pixValid, pixOut}, 17'h0);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", {pixValid, pixOut}, 17'h0);

    // R2: pattern enable without test enable is ignored
    modeSel = 3'd0; startLen = 12'd1; validWidth = 12'd4; fixedCode = 16'h5A5A;
    patEn = 1'b1;
    lineStart = 1'b1;
    @(negedge clk);
    lineStart = 1'b0;
    repeat (8) begin
      @(negedge clk);
      check("R2", {pixValid, pixOut}, 17'h0);
    end
    // R3: enabling alone starts nothing
    testEn = 1'b1;
    repeat (4) begin
      @(negedge clk);
      check("R3", {pixValid, pixOut}, 17'h0);
    end
    freeCnt = 0;
    runLine(0, 1, 4, 16'h5A5A, 0, 7);

    // table of modes, two lines each (R11 repeat)
    for (int i = 0; i < NVEC; i++) begin
      armWith(int'(VECS[i].mode), int'(VECS[i].s), int'(VECS[i].w), VECS[i].fx);
      runLine(int'(VECS[i].mode), int'(VECS[i].s), int'(VECS[i].w), VECS[i].fx, 0,
              int'(VECS[i].s) + int'(VECS[i].w) + 2);
      runLine(int'(VECS[i].mode), int'(VECS[i].s), int'(VECS[i].w), VECS[i].fx, 1,
              int'(VECS[i].s) + int'(VECS[i].w) + 2);
    end

    // R10: register writes while armed are ignored
    armWith(1, 1, 4, 16'h0);
    runLine(1, 1, 4, 16'h0, 0, 7);
    modeSel = 3'd0; startLen = 12'd5; validWidth = 12'd2; fixedCode = 16'hC3C3;
    @(negedge clk);
    lineStart = 1'b1;
    @(negedge clk);
    lineStart = 1'b0;
    for (int p = 0; p < 7; p++) begin
      @(negedge clk);
      if (p < 1)      check("R10", {pixValid, pixOut}, {1'b1, 16'h0000});
      else if (p < 5) check("R10", {pixValid, pixOut}, {1'b1, 16'(p - 1)});
      else            check("R10", {pixValid, pixOut}, {1'b0, 16'h0000});
    end
    // re-arm picks up the new settings
    armWith(0, 5, 2, 16'hC3C3);
    runLine(0, 5, 2, 16'hC3C3, 0, 9);

    // R11: edge in the middle of a line restarts it
    armWith(1, 0, 10, 16'h0);
    runLine(1, 0, 10, 16'h0, 0, 3);
    runLine(1, 0, 10, 16'h0, 1, 12);

    // R2: clearing the pattern enable mid-line idles two edges later
    armWith(1, 0, 10, 16'h0);
    runLine(1, 0, 10, 16'h0, 0, 3);
    patEn = 1'b0;
    @(negedge clk);
    check("R2", {pixValid, pixOut}, {1'b1, 16'd3});
    repeat (3) begin
      @(negedge clk);
      check("R2", {pixValid, pixOut}, 17'h0);
    end
    // line-start while disarmed stays idle
    lineStart = 1'b1;
    @(negedge clk);
    lineStart = 1'b0;
    repeat (4) begin
      @(negedge clk);
      check("R2", {pixValid, pixOut}, 17'h0);
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule